// File: doc/BRIEF.md
# Buffered Serial Transmitter with Empty Flag

This block turns parallel words from a host into an asynchronous serial stream. A word offered on the input port is captured into a holding register. A numbered slot sequencer then moves the word into a shift register and drives the line. Each frame has one guard bit (line high), then a low start bit, then the data bits with the least significant bit first, then an optional parity bit, and finally a high stop bit. Between frames the line rests high.

Timing comes from a one-cycle `tick` enable that pulses at OVERSAMPLE times the bit rate. Every serial bit lasts exactly OVERSAMPLE ticks. The input uses a valid/ready pair, and `s_ready` is the empty flag. It drops when a word is accepted. It rises again when the stop bit of that word begins, so the next word can be loaded while the stop bit is still on the line.

`s_valid` is a single-cycle write strobe, not a held request. A strobe seen while `s_ready` is low gets no back-pressure: the word is dropped, and a sticky `overrun` flag records the loss. Parity is set per frame by `par_en` and `par_odd`, which are sampled when the frame starts.

Top module: `uart_txb`

## Requirements
- R1: After reset `txd` is 1, `s_ready` is 1 and `overrun` is 0. With no write, the line stays high indefinitely.
- R2: A cycle with `s_valid` and `s_ready` both high captures `s_data`, and `s_ready` reads 0 on the following cycle.
- R3: A frame is sent in this order: one guard bit at 1, a start bit at 0, DATA_W data bits with bit 0 first, the optional parity bit, and a stop bit at 1. When the host writes while the line is idle, the guard bit begins on the first tick after the write.
- R4: Every serial bit lasts exactly OVERSAMPLE ticks. `txd` changes only on clock edges where `tick` is high.
- R5: When `par_en` is 1, a parity bit follows the data. It equals the XOR of the data bits, inverted when `par_odd` is 1 (0 selects even parity). When `par_en` is 0 the stop bit follows the last data bit directly.
- R6: `par_en` and `par_odd` are sampled when the guard bit begins. Changing them later has no effect on that frame.
- R7: `s_ready` rises on the same edge as the stop bit begins. A word written after that point is sent immediately after the stop bit, beginning with its guard bit.
- R8: A strobe on `s_valid` while `s_ready` is 0 does not alter the frame in progress. It also does not queue a frame, and it sets `overrun`, which stays 1 until reset.
- R9: `s_ready` stays 0 from an accepted write until that word's stop bit begins.
- R10: `txd` is 1 whenever the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Enable at OVERSAMPLE times the bit rate |
| par_en | input | 1 | 1 inserts a parity bit |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| s_valid | input | 1 | Write strobe for `s_data` |
| s_ready | output | 1 | Empty flag: the holding register may be written |
| s_data | input | DATA_W | Word to transmit |
| txd | output | 1 | Serial line, idles high |
| overrun | output | 1 | Sticky flag: a write was lost |

## Verification
The bench builds the block with DATA_W=8 and OVERSAMPLE=4. The short bit time lets dozens of frames run, both with and without parity and in both parity senses. It also makes exact run-length checks practical: a frame of all zeros must hold the line low for 9×4 ticks. The tick enable arrives with random gaps, so bit timing is measured in ticks rather than cycles. Directed cases cover a write landing during the stop bit, a strobe during a busy frame, and a parity setting changed after a frame has started.

// File: rtl/uart_txb_pkg.sv
package uart_txb_pkg;

  // Parity settings captured at the start of each frame.
  typedef struct packed {
    logic en;
    logic odd;
  } par_cfg_t;

  // Slot numbering: 0 idle, 1 guard, 2 start, 3.. data, then parity, then stop.
  function automatic int slot_count(input int dw);
    return dw + 5;
  endfunction

  function automatic int slot_last_data(input int dw);
    return dw + 2;
  endfunction

  function automatic int slot_parity(input int dw);
    return dw + 3;
  endfunction

  function automatic int slot_stop(input int dw);
    return dw + 4;
  endfunction

endpackage

// File: rtl/uart_txb_bit_timer.sv
module uart_txb_bit_timer #(
  parameter int OVERSAMPLE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic busy,
  output logic bit_end
);
  localparam int CW = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
  localparam logic [CW-1:0] LAST = CW'(OVERSAMPLE - 1);

  logic [CW-1:0] sub_q;

  assign bit_end = busy && tick && (sub_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q <= '0;
    end else if (!busy) begin
      sub_q <= '0;
    end else if (tick) begin
      sub_q <= (sub_q == LAST) ? '0 : sub_q + 1'b1;
    end
  end
endmodule

// File: rtl/uart_txb_slot_seq.sv
module uart_txb_slot_seq #(
  parameter int DATA_W = 8,
  parameter int SW     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          bit_end,
  input  logic          pending,
  input  logic          par_on,
  output logic [SW-1:0] slot,
  output logic [SW-1:0] slot_nxt,
  output logic          advance,
  output logic          busy
);
  localparam logic [SW-1:0] S_IDLE  = '0;
  localparam logic [SW-1:0] S_GUARD = SW'(1);
  localparam logic [SW-1:0] S_LASTD = SW'(uart_txb_pkg::slot_last_data(DATA_W));
  localparam logic [SW-1:0] S_PAR   = SW'(uart_txb_pkg::slot_parity(DATA_W));
  localparam logic [SW-1:0] S_STOP  = SW'(uart_txb_pkg::slot_stop(DATA_W));

  logic [SW-1:0] slot_q;

  assign slot = slot_q;
  assign busy = (slot_q != S_IDLE);

  always_comb begin
    if (slot_q == S_IDLE) begin
      advance  = tick && pending;
      slot_nxt = S_GUARD;
    end else begin
      advance = bit_end;
      if (slot_q == S_LASTD) begin
        slot_nxt = par_on ? S_PAR : S_STOP;
      end else if (slot_q == S_STOP) begin
        slot_nxt = pending ? S_GUARD : S_IDLE;
      end else begin
        slot_nxt = slot_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= S_IDLE;
    end else if (advance) begin
      slot_q <= slot_nxt;
    end
  end
endmodule

// File: rtl/uart_txb_serializer.sv
module uart_txb_serializer #(
  parameter int DATA_W = 8,
  parameter int SW     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  input  logic [SW-1:0]     slot_nxt,
  input  logic [DATA_W-1:0] hold,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              par_on,
  output logic              txd
);
  import uart_txb_pkg::*;

  localparam logic [SW-1:0] S_GUARD = SW'(1);
  localparam logic [SW-1:0] S_START = SW'(2);
  localparam logic [SW-1:0] S_D0    = SW'(3);
  localparam logic [SW-1:0] S_LASTD = SW'(slot_last_data(DATA_W));
  localparam logic [SW-1:0] S_PAR   = SW'(slot_parity(DATA_W));

  logic [DATA_W-1:0] sr_q;
  logic              acc_q;
  logic              txd_q;
  par_cfg_t          cfg_q;

  assign par_on = cfg_q.en;
  assign txd    = txd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      acc_q <= 1'b0;
      txd_q <= 1'b1;
      cfg_q <= '0;
    end else if (advance) begin
      if (slot_nxt == S_GUARD) begin
        sr_q      <= hold;
        acc_q     <= 1'b0;
        cfg_q.en  <= par_en;
        cfg_q.odd <= par_odd;
        txd_q     <= 1'b1;
      end else if (slot_nxt == S_START) begin
        txd_q <= 1'b0;
      end else if (slot_nxt >= S_D0 && slot_nxt <= S_LASTD) begin
        txd_q <= sr_q[0];
        acc_q <= acc_q ^ sr_q[0];
        sr_q  <= {1'b0, sr_q[DATA_W-1:1]};
      end else if (slot_nxt == S_PAR) begin
        txd_q <= acc_q ^ cfg_q.odd;
      end else begin
        txd_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_txb.sv
module uart_txb #(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  output logic              txd,
  output logic              overrun
);
  localparam int SW = $clog2(uart_txb_pkg::slot_count(DATA_W));
  localparam logic [SW-1:0] S_STOP = SW'(uart_txb_pkg::slot_stop(DATA_W));

  logic [DATA_W-1:0] hold_q;
  logic              empty_q;
  logic              ovr_q;
  logic [SW-1:0]     slot;
  logic [SW-1:0]     slot_nxt;
  logic              advance;
  logic              busy;
  logic              bit_end;
  logic              par_on;
  logic              accept;

  assign accept  = s_valid && empty_q;
  assign s_ready = empty_q;
  assign overrun = ovr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      empty_q <= 1'b1;
      ovr_q   <= 1'b0;
    end else begin
      if (accept) begin
        hold_q  <= s_data;
        empty_q <= 1'b0;
      end else if (advance && slot_nxt == S_STOP) begin
        empty_q <= 1'b1;
      end
      if (s_valid && !empty_q) begin
        ovr_q <= 1'b1;
      end
    end
  end

  uart_txb_bit_timer #(.OVERSAMPLE(OVERSAMPLE)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .busy    (busy),
    .bit_end (bit_end)
  );

  uart_txb_slot_seq #(.DATA_W(DATA_W), .SW(SW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .bit_end  (bit_end),
    .pending  (!empty_q),
    .par_on   (par_on),
    .slot     (slot),
    .slot_nxt (slot_nxt),
    .advance  (advance),
    .busy     (busy)
  );

  uart_txb_serializer #(.DATA_W(DATA_W), .SW(SW)) u_ser (
    .clk      (clk),
    .rst_n    (rst_n),
    .advance  (advance),
    .slot_nxt (slot_nxt),
    .hold     (hold_q),
    .par_en   (par_en),
    .par_odd  (par_odd),
    .par_on   (par_on),
    .txd      (txd)
  );
endmodule

// File: rtl/uart_txb_chk.sv
module uart_txb_chk #(
  parameter int SW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          s_valid,
  input logic          s_ready,
  input logic          txd,
  input logic          overrun,
  input logic [SW-1:0] slot
);
  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_ready |=> !s_ready); // R2

  AST_TXD_ON_TICK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(txd)); // R4

  AST_READY_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(s_ready) |-> txd && $past(tick)); // R7

  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && !s_ready |=> overrun); // R8

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun); // R8

  AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(txd) |-> !s_ready); // R9

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    slot == '0 |-> txd); // R10
endmodule

bind uart_txb uart_txb_chk #(.SW(SW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick    (tick),
  .s_valid (s_valid),
  .s_ready (s_ready),
  .txd     (txd),
  .overrun (overrun),
  .slot    (slot)
);

// File: tb/sim_uart_txb.sv
module sim_uart_txb;
  localparam int DW = 8;
  localparam int OS = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic          par_en = 1'b0;
  logic          par_odd = 1'b0;
  logic          s_valid = 1'b0;
  logic [DW-1:0] s_data = '0;
  logic          s_ready;
  logic          txd;
  logic          overrun;
  int            checks = 0;
  int            errors = 0;
  bit            tick_rand = 1'b0;

  always #5 clk = ~clk;

  uart_txb #(.DATA_W(DW), .OVERSAMPLE(OS)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .par_en(par_en), .par_odd(par_odd),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .txd(txd), .overrun(overrun)
  );

  always @(negedge clk) tick <= rst_n && (!tick_rand || ($urandom % 3 == 0));

  function automatic logic exp_parity(input logic [DW-1:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_tick();
    do @(posedge clk); while (!tick);
    @(negedge clk);
  endtask

  task automatic write(input logic [DW-1:0] d);
    @(negedge clk);
    s_valid = 1'b1;
    s_data  = d;
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic decode(input logic [DW-1:0] exp_d, input logic pen, input logic podd,
                        input bit chk_ready);
    logic [DW-1:0] got;
    got = '0;
    do @(negedge clk); while (txd !== 1'b0);
    repeat (OS / 2) wait_tick();
    check("R3 start bit", txd, 0);
    check("R9 ready low in frame", s_ready, 0);
    for (int i = 0; i < DW; i++) begin
      repeat (OS) wait_tick();
      got[i] = txd;
    end
    check("R3 data lsb first", got, exp_d);
    if (pen) begin
      repeat (OS) wait_tick();
      check("R5 parity bit", txd, exp_parity(exp_d, podd));
    end
    repeat (OS) wait_tick();
    check("R3 R5 stop bit", txd, 1);
    if (chk_ready) check("R7 ready in stop bit", s_ready, 1);
  endtask

  initial begin
    logic [DW-1:0] d;
    logic          pe;
    logic          po;
    int            n;
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    check("R1 reset txd", txd, 1);
    check("R1 reset ready", s_ready, 1);
    check("R1 reset overrun", overrun, 0);
    rst_n = 1'b1;
    n = 0;
    repeat (4 * OS) begin
      wait_tick();
      if (txd !== 1'b1) n++;
    end
    check("R1 idle line stays high", n, 0);

    // R2: accepted write drops ready; R3 guard bit timing
    write(8'h00);
    check("R2 ready low after write", s_ready, 0);
    n = 0;
    do begin wait_tick(); n++; end while (txd !== 1'b0);
    check("R3 guard bit before start", n, OS + 1);
    n = 0;
    do begin wait_tick(); n++; end while (txd !== 1'b1);
    check("R4 low run for zero word", n, 9 * OS);
    do @(negedge clk); while (!s_ready);
    repeat (2 * OS) wait_tick();

    write(8'hFF);
    do @(negedge clk); while (txd !== 1'b0);
    n = 0;
    do begin wait_tick(); n++; end while (txd !== 1'b1);
    check("R4 start bit length", n, OS);
    do @(negedge clk); while (!s_ready);
    repeat (2 * OS) wait_tick();

    // R5 directed parity cases
    tick_rand = 1'b1;
    par_en = 1'b1; par_odd = 1'b0; write(8'h55); decode(8'h55, 1'b1, 1'b0, 1'b1);
    par_en = 1'b1; par_odd = 1'b1; write(8'h01); decode(8'h01, 1'b1, 1'b1, 1'b1);
    par_en = 1'b0; par_odd = 1'b1; write(8'h80); decode(8'h80, 1'b0, 1'b1, 1'b1);
    check("R8 no overrun after legal writes", overrun, 0);

    // R6: configuration change after the frame has started
    par_en = 1'b1; par_odd = 1'b0;
    write(8'h07);
    fork
      decode(8'h07, 1'b1, 1'b0, 1'b1);
      begin repeat (2) wait_tick(); par_en = 1'b0; par_odd = 1'b1; end
    join
    do @(negedge clk); while (!s_ready);
    repeat (2 * OS) wait_tick();

    // R7: write during the stop bit is sent right after it
    par_en = 1'b0; par_odd = 1'b0;
    write(8'hA5);
    fork
      decode(8'hA5, 1'b0, 1'b0, 1'b0);
      begin
        do @(negedge clk); while (!s_ready);
        check("R7 ready rises in stop bit", txd, 1);
        write(8'h3C);
      end
    join
    n = 0;
    do begin wait_tick(); n++; end while (txd !== 1'b0);
    check("R7 next start after stop and guard", n, OS / 2 + OS);
    n = 0;
    repeat (OS / 2) wait_tick();
    d = '0;
    for (int i = 0; i < DW; i++) begin repeat (OS) wait_tick(); d[i] = txd; end
    check("R7 back-to-back word", d, 8'h3C);
    do @(negedge clk); while (!s_ready);
    repeat (2 * OS) wait_tick();

    // R8: strobe while busy is dropped and flagged
    par_en = 1'b1; par_odd = 1'b1;
    write(8'hC3);
    fork
      decode(8'hC3, 1'b1, 1'b1, 1'b1);
      begin
        repeat (4 * OS) wait_tick();
        write(8'h5A);
        check("R8 overrun set", overrun, 1);
        check("R8 ready still low", s_ready, 0);
      end
    join
    n = 0;
    repeat (4 * OS) begin wait_tick(); if (txd !== 1'b1) n++; end
    check("R8 dropped word not sent", n, 0);
    check("R8 overrun sticky", overrun, 1);

    // random frames
    for (int k = 0; k < 30; k++) begin
      d  = DW'($urandom);
      pe = 1'($urandom);
      po = 1'($urandom);
      par_en = pe; par_odd = po;
      do @(negedge clk); while (!s_ready);
      write(d);
      decode(d, pe, po, 1'b1);
    end
    check("R8 overrun still set", overrun, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule